// File: doc/BRIEF.md
# Priority Hardware Context Scheduler

This block decides, every clock cycle, which of five hardware contexts owns the processor. Each context has a small control word with two fields: a run state and a 3-bit priority. The state is one of Halted, Waiting or Ready. The scheduler grants the processor to the best Ready context. Context 0 is the master. Its priority is fixed at the top value, and it is the only context whose writes can change any control word.

Contexts move between states for several reasons. The running context can put itself to sleep. A per-context interrupt event wakes a sleeping context. A per-context halt request stands for a critical fault or an exhausted time budget, and it stops a context outright. The master can also set any control word directly. The selection output is combinational from the registered state, so a state change shows on the selection one cycle after the event that caused it. A combinational read port returns the state and priority of any context.

Top module: `ctx_scheduler`

## Requirements
- R1: After reset, context 0 is Ready and contexts 1 to 4 are Halted with priority 0. The selection output is then valid with ID 0.
- R2: Context 0's priority always reads back as 7. Writes to its priority field have no effect on scheduling or readback.
- R3: While any context is Ready, `sel_valid_o` is high and `sel_id_o` names the Ready context with the highest effective priority. Context 0 counts as priority 7.
- R4: When two or more Ready contexts share the highest priority, the one with the lowest number is selected.
- R5: `sleep_i` moves the currently selected context from Ready (2'b10) to Waiting (2'b01) at the next edge. Other contexts are unaffected, and `sleep_i` has no effect while nothing is selected.
- R6: A `wake_i[k]` pulse moves context k from Waiting to Ready at the next edge. It has no effect on a Halted or Ready context.
- R7: A write with `wr_en_i` high and writer ID 0 loads the target context's state and priority at the next edge. The state encoding is 2'b00 Halted, 2'b01 Waiting, 2'b10 Ready. A write to the same context takes precedence over a sleep or a wake in that cycle.
- R8: Writes are ignored entirely when the writer ID is not 0, when the state value is 2'b11, or when the target ID is 5 or more.
- R9: `halt_req_i[k]` for k from 1 to 4 forces context k to Halted at the next edge. It overrides a wake, a sleep or a master write to that context in the same cycle, although a master write still loads the priority. Bit 0 of `halt_req_i` is ignored.
- R10: While no context is Ready, `sel_valid_o` is low and `sel_id_o` keeps the last selected ID.
- R11: `rd_state_o` and `rd_prio_o` return the state and priority of context `rd_idx_i` in the same cycle. They read zero for an index of 5 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 5 | Per-context interrupt wake events |
| sleep_i | input | 1 | Sleep request from the running context |
| halt_req_i | input | 5 | Per-context fault / budget halt requests (bit 0 unused) |
| wr_en_i | input | 1 | Control word write strobe |
| wr_src_i | input | 3 | ID of the context issuing the write |
| wr_tgt_i | input | 3 | Context whose control word is written |
| wr_state_i | input | 2 | New state value |
| wr_prio_i | input | 3 | New priority value |
| rd_idx_i | input | 3 | Context selected for readback |
| rd_state_o | output | 2 | State of the context named by rd_idx_i |
| rd_prio_o | output | 3 | Priority of the context named by rd_idx_i |
| sel_id_o | output | 3 | Selected context ID |
| sel_valid_o | output | 1 | High while some context is Ready |

## Verification
A corrupted state register appears at the ports in two ways. The readback for that context differs from the expected value at once, and the selection shows either a context that should not run or a missing grant one cycle after the event that caused the corruption. Sleep, wake, halt and write collisions are resolved by a precedence order, and a mistake there shows as a wrong state one edge later. The bench compares every output in every cycle against a model that follows the requirements, so each such error is reported within the cycle it first becomes visible. Ties and the idle hold case are set up by directed sequences, so that they cannot depend on the random stream reaching them.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

    localparam int unsigned CTX_COUNT = 5;
    localparam int unsigned CTX_PRIO_W = 3;

    typedef enum logic [1:0] {
        CS_HALT  = 2'b00,
        CS_WAIT  = 2'b01,
        CS_READY = 2'b10
    } ctx_state_e;

    // A state code the write port accepts.
    function automatic logic state_code_ok(input logic [1:0] code);
        return code != 2'b11;
    endfunction

endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
    import ctx_sched_pkg::*;
#(
    parameter int unsigned PRIO_W    = CTX_PRIO_W,
    parameter bit          IS_MASTER = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake,
    input  logic              sleep,
    input  logic              halt,
    input  logic              wr_hit,
    input  logic [1:0]        wr_state,
    input  logic [PRIO_W-1:0] wr_prio,
    output logic [1:0]        state_o,
    output logic [PRIO_W-1:0] prio_o
);
    localparam logic [PRIO_W-1:0] TOP_PRIO = {PRIO_W{1'b1}};
    localparam ctx_state_e RST_STATE = IS_MASTER ? CS_READY : CS_HALT;

    ctx_state_e        state_q, state_d;
    logic [PRIO_W-1:0] prio_q;

    // Precedence, lowest first: wake, sleep, master write, halt.
    always_comb begin
        state_d = state_q;
        if (wake && state_q == CS_WAIT)   state_d = CS_READY;
        if (sleep && state_q == CS_READY) state_d = CS_WAIT;
        if (wr_hit)                       state_d = ctx_state_e'(wr_state);
        if (halt && !IS_MASTER)           state_d = CS_HALT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RST_STATE;
            prio_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr_hit && !IS_MASTER) prio_q <= wr_prio;
        end
    end

    assign state_o = state_q;
    assign prio_o  = IS_MASTER ? TOP_PRIO : prio_q;

endmodule

// File: rtl/ctx_pick.sv
module ctx_pick #(
    parameter int unsigned N_CTX  = 5,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned ID_W  = $clog2(N_CTX)
) (
    input  logic [N_CTX-1:0]             ready,
    input  logic [N_CTX-1:0][PRIO_W-1:0] prio,
    output logic [ID_W-1:0]              win_id,
    output logic                         any
);
    logic [PRIO_W-1:0] best;

    // Scanning from the top index down with >= lets a lower index win a tie.
    always_comb begin
        win_id = '0;
        best   = '0;
        any    = 1'b0;
        for (int i = N_CTX - 1; i >= 0; i--) begin
            if (ready[i] && (!any || prio[i] >= best)) begin
                any    = 1'b1;
                best   = prio[i];
                win_id = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/ctx_scheduler.sv
module ctx_scheduler
    import ctx_sched_pkg::*;
#(
    parameter int unsigned N_CTX  = CTX_COUNT,
    parameter int unsigned PRIO_W = CTX_PRIO_W,
    localparam int unsigned ID_W  = $clog2(N_CTX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CTX-1:0]  wake_i,
    input  logic              sleep_i,
    input  logic [N_CTX-1:0]  halt_req_i,
    input  logic              wr_en_i,
    input  logic [ID_W-1:0]   wr_src_i,
    input  logic [ID_W-1:0]   wr_tgt_i,
    input  logic [1:0]        wr_state_i,
    input  logic [PRIO_W-1:0] wr_prio_i,
    input  logic [ID_W-1:0]   rd_idx_i,
    output logic [1:0]        rd_state_o,
    output logic [PRIO_W-1:0] rd_prio_o,
    output logic [ID_W-1:0]   sel_id_o,
    output logic              sel_valid_o
);
    localparam logic [ID_W:0] CTX_LIMIT = (ID_W + 1)'(N_CTX);

    logic [N_CTX-1:0][1:0]        st_vec;
    logic [N_CTX-1:0][PRIO_W-1:0] pr_vec;
    logic [N_CTX-1:0]             ready_vec;
    logic [ID_W-1:0]              win_id;
    logic                         any_ready;
    logic [ID_W-1:0]              last_q;
    logic                         wr_ok;

    assign wr_ok = wr_en_i && (wr_src_i == '0) && state_code_ok(wr_state_i)
                && ({1'b0, wr_tgt_i} < CTX_LIMIT);

    for (genvar k = 0; k < N_CTX; k++) begin : g_slot
        ctx_slot #(
            .PRIO_W   (PRIO_W),
            .IS_MASTER(k == 0)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wake    (wake_i[k]),
            .sleep   (sleep_i && sel_valid_o && sel_id_o == ID_W'(k)),
            .halt    (halt_req_i[k]),
            .wr_hit  (wr_ok && wr_tgt_i == ID_W'(k)),
            .wr_state(wr_state_i),
            .wr_prio (wr_prio_i),
            .state_o (st_vec[k]),
            .prio_o  (pr_vec[k])
        );
        assign ready_vec[k] = (st_vec[k] == CS_READY);
    end

    ctx_pick #(
        .N_CTX (N_CTX),
        .PRIO_W(PRIO_W)
    ) u_pick (
        .ready (ready_vec),
        .prio  (pr_vec),
        .win_id(win_id),
        .any   (any_ready)
    );

    assign sel_valid_o = any_ready;
    assign sel_id_o    = any_ready ? win_id : last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= sel_id_o;
    end

    always_comb begin
        rd_state_o = '0;
        rd_prio_o  = '0;
        if ({1'b0, rd_idx_i} < CTX_LIMIT) begin
            rd_state_o = st_vec[rd_idx_i];
            rd_prio_o  = pr_vec[rd_idx_i];
        end
    end

endmodule

// File: rtl/ctx_scheduler_chk.sv
module ctx_scheduler_chk #(
    parameter int unsigned N_CTX  = 5,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned ID_W  = $clog2(N_CTX)
) (
    input logic                         clk,
    input logic                         rst,
    input logic [N_CTX-1:0]             halt_req_i,
    input logic                         wr_en_i,
    input logic [ID_W-1:0]              wr_src_i,
    input logic [ID_W-1:0]              rd_idx_i,
    input logic [PRIO_W-1:0]            rd_prio_o,
    input logic [ID_W-1:0]              sel_id_o,
    input logic                         sel_valid_o,
    input logic [N_CTX-1:0][1:0]        st_vec,
    input logic [N_CTX-1:0][PRIO_W-1:0] pr_vec
);
    localparam logic [PRIO_W-1:0] TOP_PRIO = {PRIO_W{1'b1}};

    // R2
    master_prio_top_chk: assert property (@(posedge clk) disable iff (rst)
        rd_idx_i == '0 |-> rd_prio_o == TOP_PRIO);

    // R3
    sel_is_ready_chk: assert property (@(posedge clk) disable iff (rst)
        sel_valid_o |-> st_vec[sel_id_o] == 2'b10);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_valid_o |-> $stable(sel_id_o));

    // R8
    foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_src_i != '0) |=> $stable(pr_vec));

    for (genvar k = 1; k < N_CTX; k++) begin : g_halt
        // R9
        halt_wins_chk: assert property (@(posedge clk) disable iff (rst)
            halt_req_i[k] |=> st_vec[k] == 2'b00);
    end

endmodule

bind ctx_scheduler ctx_scheduler_chk #(
    .N_CTX (N_CTX),
    .PRIO_W(PRIO_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .halt_req_i (halt_req_i),
    .wr_en_i    (wr_en_i),
    .wr_src_i   (wr_src_i),
    .rd_idx_i   (rd_idx_i),
    .rd_prio_o  (rd_prio_o),
    .sel_id_o   (sel_id_o),
    .sel_valid_o(sel_valid_o),
    .st_vec     (st_vec),
    .pr_vec     (pr_vec)
);

// File: tb/ctx_scheduler_bench.sv
module ctx_scheduler_bench;
    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] wake_i = '0;
    logic       sleep_i = 1'b0;
    logic [4:0] halt_req_i = '0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_src_i = '0;
    logic [2:0] wr_tgt_i = '0;
    logic [1:0] wr_state_i = '0;
    logic [2:0] wr_prio_i = '0;
    logic [2:0] rd_idx_i = '0;
    logic [1:0] rd_state_o;
    logic [2:0] rd_prio_o;
    logic [2:0] sel_id_o;
    logic       sel_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_st [N];
    int m_pr [N];
    int m_last;

    always #4 clk = ~clk;

    ctx_scheduler u_ctx_scheduler (
        .clk(clk), .rst(rst), .wake_i(wake_i), .sleep_i(sleep_i),
        .halt_req_i(halt_req_i), .wr_en_i(wr_en_i), .wr_src_i(wr_src_i),
        .wr_tgt_i(wr_tgt_i), .wr_state_i(wr_state_i), .wr_prio_i(wr_prio_i),
        .rd_idx_i(rd_idx_i), .rd_state_o(rd_state_o), .rd_prio_o(rd_prio_o),
        .sel_id_o(sel_id_o), .sel_valid_o(sel_valid_o)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int eff_prio(input int k);
        return (k == 0) ? 7 : m_pr[k];
    endfunction

    function automatic int exp_win();
        int w = -1;
        for (int k = 0; k < N; k++)
            if (m_st[k] == 2 && (w < 0 || eff_prio(k) > eff_prio(w))) w = k;
        return w;
    endfunction

    task automatic idle();
        wake_i = '0; sleep_i = 0; halt_req_i = '0; wr_en_i = 0;
        wr_src_i = '0; wr_tgt_i = '0; wr_state_i = '0; wr_prio_i = '0;
    endtask

    task automatic master_wr(input int tgt, input int st, input int pr);
        wr_en_i = 1; wr_src_i = 0; wr_tgt_i = 3'(tgt);
        wr_state_i = 2'(st); wr_prio_i = 3'(pr);
    endtask

    // Compare outputs for the current model state, then advance the model
    // with the inputs that are being applied this cycle.
    task automatic step(input string tag);
        int w, ri, ns;
        int nst [N];
        bit hit;
        #1;
        w = exp_win();
        check(tag, "sel_valid", int'(sel_valid_o), (w >= 0) ? 1 : 0);
        check(tag, "sel_id", int'(sel_id_o), (w >= 0) ? w : m_last);
        ri = int'(rd_idx_i);
        check(tag, "rd_state", int'(rd_state_o), (ri < N) ? m_st[ri] : 0);
        check(tag, "rd_prio", int'(rd_prio_o), (ri < N) ? eff_prio(ri) : 0);
        if (w >= 0) m_last = w;
        for (int k = 0; k < N; k++) begin
            ns = m_st[k];
            hit = wr_en_i && wr_src_i == 0 && wr_state_i != 2'b11 && int'(wr_tgt_i) == k;
            if (wake_i[k] && m_st[k] == 1) ns = 2;
            if (sleep_i && w == k && m_st[k] == 2) ns = 1;
            if (hit) ns = int'(wr_state_i);
            if (halt_req_i[k] && k != 0) ns = 0;
            nst[k] = ns;
            if (hit && k != 0) m_pr[k] = int'(wr_prio_i);
        end
        for (int k = 0; k < N; k++) m_st[k] = nst[k];
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        m_st[0] = 2; m_pr[0] = 0;
        for (int k = 1; k < N; k++) begin m_st[k] = 0; m_pr[k] = 0; end
        m_last = 0;

        // R1: reset values read back for every context
        for (int k = 0; k < N; k++) begin
            rd_idx_i = 3'(k);
            step("R1");
        end

        // R7: master brings up contexts 2 and 3 at equal priority
        master_wr(2, 2, 3); step("R7");
        master_wr(3, 2, 3); step("R7");
        idle();
        // R5: master (running) sleeps; R4: tie 2 vs 3 -> 2
        sleep_i = 1; step("R5");
        idle(); rd_idx_i = 0; step("R4");
        // R3: higher priority context 1 takes over
        master_wr(1, 2, 5); step("R3");
        idle(); rd_idx_i = 1; step("R3");
        // R8: foreign writer, reserved code, out of range target
        wr_en_i = 1; wr_src_i = 2; wr_tgt_i = 1; wr_state_i = 0; wr_prio_i = 0;
        step("R8");
        master_wr(1, 3, 0); step("R8");
        master_wr(6, 0, 1); rd_idx_i = 6; step("R11");
        idle(); rd_idx_i = 1; step("R8");
        // R9: context 1 sleeps, then halt and wake collide
        sleep_i = 1; step("R5");
        idle(); halt_req_i[1] = 1; wake_i[1] = 1; step("R9");
        idle(); step("R9");
        // R9: halt bit 0 ignored
        halt_req_i[0] = 1; rd_idx_i = 0; step("R9");
        // R10: halt 2 and 3 while master sleeps -> nothing ready
        idle(); halt_req_i[2] = 1; halt_req_i[3] = 1; step("R10");
        idle(); sleep_i = 1; step("R10");
        idle(); step("R10");
        sleep_i = 1; step("R10");
        idle(); wake_i[4] = 1; step("R6");
        idle(); wake_i[0] = 1; step("R6");
        // R2: master priority write ignored
        idle(); master_wr(0, 2, 1); rd_idx_i = 0; step("R2");
        idle(); step("R2");

        // Random phase covering R3 R4 R5 R6 R7 R9 R11
        for (int c = 0; c < 4000; c++) begin
            idle();
            for (int k = 0; k < N; k++) begin
                wake_i[k]     = ($urandom % 6) == 0;
                halt_req_i[k] = ($urandom % 20) == 0;
            end
            sleep_i = ($urandom % 5) == 0;
            if (($urandom % 3) == 0) begin
                wr_en_i    = 1;
                wr_src_i   = (($urandom % 4) == 0) ? 3'($urandom % 5) : 3'd0;
                wr_tgt_i   = 3'($urandom % 8);
                wr_state_i = 2'($urandom % 4);
                wr_prio_i  = 3'($urandom % 8);
                if (wr_tgt_i == 0 && wr_state_i == 2'b00) wr_state_i = 2'b01;
            end
            rd_idx_i = 3'($urandom % 8);
            step("R3/R4/R5/R6/R7/R9/R11");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule